// File: doc/BRIEF.md
# Thermal Contrast Stabilization Controller

This block keeps a thermal swipe sensor's image contrast usable. When the finger and the die are at nearly the same temperature, the pixels produce little signal. The block then switches on the sensor's on-die heater until the die has warmed by a fixed amount. It watches the 4-bit die-temperature code that a frame synchronizer extracts from each frame. That code is offset-binary: code 8 means no change, each step is about 1.4 K, and codes 0 and 15 are saturated.

A contrast monitor outside the block raises a low-contrast request. On the next frame the block accepts, it records that frame's code as the baseline. It sets the goal at two codes above the baseline and holds the heater enable high until a frame reports a code at or above the goal. A frame budget bounds the heating time. A baseline already too hot to reach the goal is refused. Both of these failures raise an error flag. After every heating attempt the block waits a cooldown of several frames, and it ignores new requests during that time. A nap indication forces the heater off at once.

Top module: `thermo_contrast_ctrl`

## Requirements
- R1: After reset `heater_en`, `busy` and `err_flag` are low and `temp_delta` is zero.
- R2: A frame counts only in a cycle where `code_valid` and `sync_locked` are both high. On such a frame `temp_delta` becomes `temp_code - 8` as a 5-bit two's-complement value, visible in the following cycle. In all other cycles it keeps its value.
- R3: In idle, a counted frame with `low_contrast_req` high, `nap` low and a code of 13 or less starts heating. From the next cycle `busy` and `heater_en` are high.
- R4: The goal is baseline + 2, clamped at 15. A heating frame that reports a code at or above the goal ends heating: from the next cycle `heater_en` is low, `busy` stays high and no error is flagged.
- R5: A request accepted with a baseline of 14 or 15 does not heat. From the next cycle `err_flag` and `busy` are high and `heater_en` is low.
- R6: During heating, the heating frame numbered `cfg_timeout_frames` (counted from 1) that misses the goal ends heating and sets `err_flag`. A budget of 0 behaves as 1.
- R7: `heater_en` is low in any cycle where `nap` is high. Nap during heating ends the attempt without an error. A request is not accepted while `nap` is high.
- R8: After each attempt `busy` stays high for `cfg_cooldown_frames` counted frames, then falls in the cycle after that count is reached. Requests arriving while heating or cooling are ignored.
- R9: `err_flag` holds its value until a new request is accepted, which clears it (or sets it again under R5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| temp_code | input | 4 | Die-temperature code from the current frame |
| code_valid | input | 1 | Strobe: `temp_code` holds a new frame's code |
| sync_locked | input | 1 | The frame synchronizer is locked |
| low_contrast_req | input | 1 | Request to restore contrast |
| nap | input | 1 | Low-power entry; forces the heater off |
| cfg_timeout_frames | input | 8 | Heating budget in counted frames |
| cfg_cooldown_frames | input | 8 | Cooldown length in counted frames |
| heater_en | output | 1 | On-die heater enable |
| busy | output | 1 | Heating or cooling in progress |
| err_flag | output | 1 | The last accepted attempt failed (timeout or too hot) |
| temp_delta | output | 5 | Signed code minus 8 of the last counted frame |

## Verification
Random stretches mix strobes with and without lock, codes over the whole range, and sparse requests and naps. They are checked cycle by cycle against a frame-level model, which separates counted frames from uncounted ones and keeps baseline and goal tracking apart from timeout counting. Directed sequences isolate single cases. A rise to exactly baseline+2 tells goal detection from an off-by-one. A request with a code of 15 during cooldown shows that requests are ignored. Baselines of 14 and 3 separate refusal from timeout. Zero budgets test the degenerate setting. A nap raised between clock edges shows the heater gating acts within the same cycle.

// File: rtl/thc_pkg.sv
// Shared constants, types and helpers for the thermal contrast controller.
// Assumes an offset-binary temperature code whose midpoint means "no change".
package thc_pkg;
    localparam int THC_CODE_W   = 4;
    localparam int THC_SUM_W    = THC_CODE_W + 1;
    localparam int THC_CODE_MAX = (1 << THC_CODE_W) - 1;
    localparam int THC_ZERO     = 1 << (THC_CODE_W - 1);
    localparam int THC_STEP     = 2;
    localparam int THC_HOT      = THC_CODE_MAX - THC_STEP + 1;

    typedef logic [THC_CODE_W-1:0] thc_code_t;

    typedef enum logic [1:0] {
        THC_IDLE = 2'd0,
        THC_HEAT = 2'd1,
        THC_COOL = 2'd2
    } thc_state_e;

    // Goal code: baseline plus the step, saturated at the top code.
    function automatic thc_code_t thc_target(input thc_code_t base);
        logic [THC_SUM_W-1:0] sum;
        sum = {1'b0, base} + THC_SUM_W'(THC_STEP);
        if (sum > THC_SUM_W'(THC_CODE_MAX))
            return thc_code_t'(THC_CODE_MAX);
        return sum[THC_CODE_W-1:0];
    endfunction
endpackage

// File: rtl/thc_frame_gate.sv
// Frame qualification: a frame counts only when the strobe and the lock are both high.
// It also registers the signed differential (code minus midpoint) of the last counted frame.
module thc_frame_gate
    import thc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst_n,
    input  thc_code_t                   temp_code,
    input  logic                        code_valid,
    input  logic                        sync_locked,
    output logic                        frame_acc,
    output logic signed [THC_SUM_W-1:0] temp_delta
);
    logic [THC_SUM_W-1:0] raw_delta;

    // Qualify the incoming frame strobe.
    always_comb frame_acc = code_valid & sync_locked;

    // Offset-binary to two's complement.
    always_comb raw_delta = {1'b0, temp_code} - THC_SUM_W'(THC_ZERO);

    // Hold the differential of the last counted frame.
    always_ff @(posedge clk) begin
        if (!rst_n)
            temp_delta <= '0;
        else if (frame_acc)
            temp_delta <= $signed(raw_delta);
    end
endmodule

// File: rtl/thc_frame_cnt.sv
// Saturating frame counter with a synchronous clear that has priority over increment.
module thc_frame_cnt #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    // Count counted frames; stop at the top value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)
            cnt <= '0;
        else if (inc && cnt != CNT_MAX)
            cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/thc_fsm.sv
// Heater control sequence: idle, heating toward baseline+STEP, then cooldown.
// Assumes the frame counters are cleared whenever the FSM is outside their state.
module thc_fsm
    import thc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_acc,
    input  thc_code_t        temp_code,
    input  logic             low_contrast_req,
    input  logic             nap,
    input  logic [CNT_W-1:0] cfg_timeout_frames,
    input  logic [CNT_W-1:0] cfg_cooldown_frames,
    input  logic [CNT_W-1:0] heat_cnt,
    input  logic [CNT_W-1:0] cool_cnt,
    output logic             heat_clr,
    output logic             heat_inc,
    output logic             cool_clr,
    output logic             cool_inc,
    output logic             heater_en,
    output logic             busy,
    output logic             err_flag
);
    thc_state_e state_q, state_d;
    thc_code_t  goal_q, goal_d;
    logic       err_d;
    logic       timeout_hit;
    logic       cool_done;
    logic       goal_hit;

    // Budget check: this frame would be the last one allowed.
    always_comb timeout_hit = ({1'b0, heat_cnt} + {{CNT_W{1'b0}}, 1'b1}) >= {1'b0, cfg_timeout_frames};

    // Cooldown ends once enough counted frames have passed.
    always_comb cool_done = cool_cnt >= cfg_cooldown_frames;

    // Goal reached by the current frame's code.
    always_comb goal_hit = temp_code >= goal_q;

    // Next-state and error decisions.
    always_comb begin
        state_d = state_q;
        goal_d  = goal_q;
        err_d   = err_flag;
        unique case (state_q)
            THC_IDLE: begin
                if (frame_acc && low_contrast_req && !nap) begin
                    if (temp_code >= thc_code_t'(THC_HOT)) begin
                        err_d   = 1'b1;
                        state_d = THC_COOL;
                    end else begin
                        err_d   = 1'b0;
                        goal_d  = thc_target(temp_code);
                        state_d = THC_HEAT;
                    end
                end
            end
            THC_HEAT: begin
                if (nap) begin
                    state_d = THC_COOL;
                end else if (frame_acc) begin
                    if (goal_hit) begin
                        state_d = THC_COOL;
                    end else if (timeout_hit) begin
                        err_d   = 1'b1;
                        state_d = THC_COOL;
                    end
                end
            end
            THC_COOL: begin
                if (cool_done)
                    state_d = THC_IDLE;
            end
            default: state_d = THC_IDLE;
        endcase
    end

    // State, goal and error registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= THC_IDLE;
            goal_q   <= '0;
            err_flag <= 1'b0;
        end else begin
            state_q  <= state_d;
            goal_q   <= goal_d;
            err_flag <= err_d;
        end
    end

    // Counter controls: each counter runs only inside its own state.
    always_comb begin
        heat_clr = state_q != THC_HEAT;
        heat_inc = (state_q == THC_HEAT) && frame_acc && !nap;
        cool_clr = state_q != THC_COOL;
        cool_inc = (state_q == THC_COOL) && frame_acc;
    end

    // Outputs; nap gates the heater without waiting for an edge.
    always_comb begin
        heater_en = (state_q == THC_HEAT) && !nap;
        busy      = state_q != THC_IDLE;
    end
endmodule

// File: rtl/thermo_contrast_ctrl.sv
// Top of the thermal contrast controller: frame gate, two frame counters, FSM.
// Assumes temp_code is stable whenever code_valid is high.
module thermo_contrast_ctrl
    import thc_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [THC_CODE_W-1:0]       temp_code,
    input  logic                        code_valid,
    input  logic                        sync_locked,
    input  logic                        low_contrast_req,
    input  logic                        nap,
    input  logic [CNT_W-1:0]            cfg_timeout_frames,
    input  logic [CNT_W-1:0]            cfg_cooldown_frames,
    output logic                        heater_en,
    output logic                        busy,
    output logic                        err_flag,
    output logic signed [THC_SUM_W-1:0] temp_delta
);
    logic             frame_acc;
    logic             heat_clr, heat_inc, cool_clr, cool_inc;
    logic [CNT_W-1:0] heat_cnt, cool_cnt;

    thc_frame_gate u_gate (
        .clk        (clk),
        .rst_n      (rst_n),
        .temp_code  (temp_code),
        .code_valid (code_valid),
        .sync_locked(sync_locked),
        .frame_acc  (frame_acc),
        .temp_delta (temp_delta)
    );

    thc_frame_cnt #(.CNT_W(CNT_W)) u_heat_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (heat_clr),
        .inc  (heat_inc),
        .cnt  (heat_cnt)
    );

    thc_frame_cnt #(.CNT_W(CNT_W)) u_cool_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cool_clr),
        .inc  (cool_inc),
        .cnt  (cool_cnt)
    );

    thc_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk                (clk),
        .rst_n              (rst_n),
        .frame_acc          (frame_acc),
        .temp_code          (temp_code),
        .low_contrast_req   (low_contrast_req),
        .nap                (nap),
        .cfg_timeout_frames (cfg_timeout_frames),
        .cfg_cooldown_frames(cfg_cooldown_frames),
        .heat_cnt           (heat_cnt),
        .cool_cnt           (cool_cnt),
        .heat_clr           (heat_clr),
        .heat_inc           (heat_inc),
        .cool_clr           (cool_clr),
        .cool_inc           (cool_inc),
        .heater_en          (heater_en),
        .busy               (busy),
        .err_flag           (err_flag)
    );
endmodule

// File: rtl/thc_chk.sv
// Port-level temporal checks for the thermal contrast controller, bound to the top.
module thc_chk
    import thc_pkg::*;
(
    input logic                        clk,
    input logic                        rst_n,
    input logic [THC_CODE_W-1:0]       temp_code,
    input logic                        code_valid,
    input logic                        sync_locked,
    input logic                        low_contrast_req,
    input logic                        nap,
    input logic                        heater_en,
    input logic                        busy,
    input logic                        err_flag,
    input logic signed [THC_SUM_W-1:0] temp_delta
);
    logic fr;
    always_comb fr = code_valid && sync_locked;

    // R7
    nap_heater_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nap |-> !heater_en);

    // R3
    heater_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        heater_en |-> busy);

    // R2
    delta_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fr |=> $stable(temp_delta));

    // R3
    start_heat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fr && low_contrast_req && !nap && temp_code < THC_CODE_W'(THC_HOT))
        |=> (busy && !err_flag));

    // R5
    hot_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && fr && low_contrast_req && !nap && temp_code >= THC_CODE_W'(THC_HOT))
        |=> (busy && err_flag && !heater_en));

    // R9
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !fr) |=> err_flag);

    // R8
    cool_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !heater_en && !nap) |=> !heater_en);
endmodule

bind thermo_contrast_ctrl thc_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .temp_code       (temp_code),
    .code_valid      (code_valid),
    .sync_locked     (sync_locked),
    .low_contrast_req(low_contrast_req),
    .nap             (nap),
    .heater_en       (heater_en),
    .busy            (busy),
    .err_flag        (err_flag),
    .temp_delta      (temp_delta)
);

// File: tb/thermo_contrast_ctrl_tb_top.sv
module thermo_contrast_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int M_IDLE = 0, M_HEAT = 1, M_COOL = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] temp_code = '0;
    logic       code_valid = 1'b0, sync_locked = 1'b0, low_contrast_req = 1'b0, nap = 1'b0;
    logic [7:0] cfg_timeout_frames = 8'd4, cfg_cooldown_frames = 8'd2;
    logic       heater_en, busy, err_flag;
    logic signed [4:0] temp_delta;

    int checks = 0, fails = 0, cycles = 0;
    int m_state = M_IDLE, m_goal = 0, m_err = 0, m_hcnt = 0, m_ccnt = 0, m_delta = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    thermo_contrast_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .temp_code(temp_code), .code_valid(code_valid),
        .sync_locked(sync_locked), .low_contrast_req(low_contrast_req), .nap(nap),
        .cfg_timeout_frames(cfg_timeout_frames), .cfg_cooldown_frames(cfg_cooldown_frames),
        .heater_en(heater_en), .busy(busy), .err_flag(err_flag), .temp_delta(temp_delta)
    );

    function automatic int goal_of(int b);
        return (b + 2 > 15) ? 15 : b + 2;
    endfunction

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    // Frame-level model of R2..R9, advanced once per clock edge.
    task automatic model_step(int v, int l, int c, int r, int n);
        int fr = v & l;
        if (fr) m_delta = c - 8;
        case (m_state)
            M_IDLE: if (fr && r && !n) begin
                m_err = 0;
                if (c >= 14) begin m_err = 1; m_state = M_COOL; m_ccnt = 0; end
                else begin m_goal = goal_of(c); m_state = M_HEAT; m_hcnt = 0; end
            end
            M_HEAT: if (n) begin m_state = M_COOL; m_ccnt = 0; end
            else if (fr) begin
                if (c >= m_goal) begin m_state = M_COOL; m_ccnt = 0; end
                else if (m_hcnt + 1 >= int'(cfg_timeout_frames)) begin
                    m_err = 1; m_state = M_COOL; m_ccnt = 0;
                end else m_hcnt++;
            end
            default: if (m_ccnt >= int'(cfg_cooldown_frames)) m_state = M_IDLE;
                     else if (fr) m_ccnt++;
        endcase
    endtask

    task automatic cyc(int v, int l, int c, int r, int n, string tag);
        @(negedge clk);
        code_valid = v[0]; sync_locked = l[0]; temp_code = c[3:0];
        low_contrast_req = r[0]; nap = n[0];
        @(posedge clk); #1;
        model_step(v, l, c, r, n);
        check({tag, " heater R3/R7"}, int'(heater_en), (m_state == M_HEAT && !n) ? 1 : 0);
        check({tag, " busy R8"}, int'(busy), (m_state != M_IDLE) ? 1 : 0);
        check({tag, " err R6/R9"}, int'(err_flag), m_err);
        check({tag, " delta R2"}, int'(temp_delta), m_delta);
    endtask

    task automatic drain();
        for (int i = 0; i < 400 && m_state != M_IDLE; i++) cyc(1, 1, 7, 0, 0, "drain");
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        check("R1 heater", int'(heater_en), 0);
        check("R1 busy", int'(busy), 0);
        check("R1 err", int'(err_flag), 0);
        check("R1 delta", int'(temp_delta), 0);
        @(negedge clk); rst_n = 1'b1;

        // R3 start, R4 goal exactly baseline+2
        cyc(1, 1, 8, 1, 0, "R3 start");
        check("R3 heater on", int'(heater_en), 1);
        cyc(1, 1, 9, 0, 0, "R4 below goal");
        check("R4 still heating", int'(heater_en), 1);
        cyc(1, 1, 10, 0, 0, "R4 goal");
        check("R4 heater off", int'(heater_en), 0);
        check("R4 no error", int'(err_flag), 0);
        // R8 request during cooldown ignored
        cyc(1, 1, 15, 1, 0, "R8 ignored");
        check("R8 ignored err", int'(err_flag), 0);
        cyc(1, 1, 3, 0, 0, "R8 cool");
        check("R8 still busy", int'(busy), 1);
        cyc(0, 0, 0, 0, 0, "R8 end");
        check("R8 idle", int'(busy), 0);

        // R5 hot baseline refused
        cyc(1, 1, 14, 1, 0, "R5 hot");
        check("R5 err", int'(err_flag), 1);
        check("R5 no heat", int'(heater_en), 0);
        drain();
        check("R9 err held", int'(err_flag), 1);

        // R6 timeout with budget 4; R2 unlocked frame not counted
        cyc(1, 1, 3, 1, 0, "R9 clear");
        check("R9 err cleared", int'(err_flag), 0);
        cyc(1, 1, 3, 0, 0, "R6 f1");
        cyc(1, 1, 4, 0, 0, "R6 f2");
        cyc(1, 0, 15, 0, 0, "R2 unlocked");
        check("R2 delta kept", int'(temp_delta), -4);
        check("R2 still heating", int'(heater_en), 1);
        cyc(1, 1, 4, 0, 0, "R6 f3");
        check("R6 before budget", int'(heater_en), 1);
        cyc(1, 1, 4, 0, 0, "R6 f4");
        check("R6 timeout err", int'(err_flag), 1);
        check("R6 heater off", int'(heater_en), 0);
        drain();

        // R7 nap gates the heater within the cycle and aborts without error
        cyc(1, 1, 6, 1, 0, "R7 start");
        @(negedge clk); code_valid = 1'b0; nap = 1'b1; #1;
        check("R7 same-cycle off", int'(heater_en), 0);
        @(posedge clk); #1;
        model_step(0, 0, 6, 0, 1);
        check("R7 abort no err", int'(err_flag), 0);
        drain();
        cyc(1, 1, 5, 1, 1, "R7 nap blocks req");
        check("R7 not started", int'(busy), 0);

        // R6 zero budget acts as one
        cfg_timeout_frames = 8'd0; cfg_cooldown_frames = 8'd0;
        cyc(1, 1, 2, 1, 0, "R6 zero start");
        cyc(1, 1, 2, 0, 0, "R6 zero budget");
        check("R6 zero err", int'(err_flag), 1);
        cyc(0, 0, 0, 0, 0, "R8 zero cool");
        check("R8 zero cool idle", int'(busy), 0);

        // Random mix checked against the model
        for (int k = 0; k < 6; k++) begin
            cfg_timeout_frames = 8'($urandom_range(0, 6));
            cfg_cooldown_frames = 8'($urandom_range(0, 4));
            for (int i = 0; i < 800; i++) begin
                int v = ($urandom_range(0, 3) != 0) ? 1 : 0;
                int l = ($urandom_range(0, 7) != 0) ? 1 : 0;
                int c = int'($urandom_range(0, 15));
                int r = ($urandom_range(0, 4) == 0) ? 1 : 0;
                int n = ($urandom_range(0, 40) == 0) ? 1 : 0;
                cyc(v, l, c, r, n, "rand");
            end
            drain();
        end
        summary();
    end

    always @(posedge clk) cycles++;
endmodule